// File: doc/BRIEF.md
# Inclusive Last-Level Cache Presence Directory

This block is the tag and presence directory of an inclusive shared cache that sits under four cores. Every resident line keeps a small vector with one bit per core. A bit is raised when that core may hold a copy in its private caches. Because the shared cache is inclusive, a miss in this directory means that no core anywhere on the die holds the line. No snoop is needed in that case. On a hit, only the other cores whose bits are raised need to be probed.

Requests arrive one at a time through a valid/ready handshake. A lookup reports hit or miss and returns the mask of cores to snoop. It also says whether the requester may take the line exclusively, and it raises the requester's bit. On a miss, the line is installed. If the victim way held a line, the response also names that line's address and the cores that must receive a back-invalidate. A release request is a core's notice that it dropped a line, and it clears only that core's bit.

The directory is a small set-associative model kept in registers. Arbitration between cores, line data, the memory path and the delivery of snoops all sit outside the block.

Top module: `llc_presence_dir`

## Requirements
- R1: After reset, rsp_valid, rsp_binv_valid and rsp_binv_mask are 0, req_ready is 1, and every way of every set is empty, so the first lookup of any address misses.
- R2: A lookup that misses returns rsp_hit=0 and a zero snoop mask. It installs the line with only the requester's bit raised. Here req_op=0 means lookup and req_op=1 means release. Address bits [log2(SETS)-1:0] select the set and the remaining upper bits form the tag.
- R3: A lookup that hits returns rsp_hit=1 and a snoop mask equal to the line's presence bits with the requester's own bit cleared. Bit i of the mask stands for core i.
- R4: A lookup hit on a line whose other-core bits are all clear returns a zero snoop mask.
- R5: After any lookup, the requester's bit is raised on the line. Later lookups by other cores see it in their snoop mask.
- R6: A release returns rsp_hit=1 if the line is resident, and then clears only the requester's bit. Releasing an absent line, or a line whose requester bit is already clear, changes nothing. A release never snoops, never grants exclusivity and never evicts.
- R7: rsp_excl is 1 on a lookup exactly when, after the access, the requester is the only core with its bit raised.
- R8: A miss fills the lowest-numbered empty way of the set. If the set is full, it fills the way named by that set's rotating pointer. The pointer starts at 0 and advances by one, modulo WAYS, on every fill of that set.
- R9: When the fill displaces a resident line, rsp_binv_valid is 1, rsp_binv_mask carries that line's presence bits and rsp_binv_addr carries its line address. Otherwise rsp_binv_valid, rsp_binv_mask and rsp_binv_addr are all 0.
- R10: Each accepted request gives exactly one response cycle (rsp_valid=1) on the clock edge after the handshake, and results are available on the next cycle. A request in the following cycle sees the state updated by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_op | input | 1 | 0 lookup, 1 release |
| req_core | input | log2(NUM_CORES) | Requesting core |
| req_addr | input | ADDR_W | Line address |
| rsp_valid | output | 1 | Response present, one cycle per request |
| rsp_hit | output | 1 | Line was resident |
| rsp_snoop_mask | output | NUM_CORES | Cores to snoop |
| rsp_excl | output | 1 | Requester may hold the line exclusively |
| rsp_binv_valid | output | 1 | A resident line was displaced |
| rsp_binv_mask | output | NUM_CORES | Cores to back-invalidate |
| rsp_binv_addr | output | ADDR_W | Line address of the displaced line |

## Verification
The bench drives hand-built sequences and then a long pseudo-random mix of lookups and releases through the directory. An arithmetic model predicts every field of every response.

The sequences target the cases below:
- A second core hitting a line that another core owns. A design that forgets to mask out the requester would snoop the requester itself.
- A line whose presence bits have all been released. A design that drops the line here would report a miss instead of a quiet hit.
- Releases of lines that are absent or already clear. A sloppy design would clear the wrong bit or disturb the line.
- Sets overfilled past their way count. A broken empty-way search or rotating pointer would evict the wrong line and report a wrong back-invalidate address or mask.
- Idle cycles between back-to-back requests. A design that stretches its response, or leaves it stale, would show up here.

// File: rtl/llc_pd_pkg.sv
package llc_pd_pkg;

  typedef enum logic {
    OP_LOOKUP  = 1'b0,
    OP_RELEASE = 1'b1
  } pd_op_e;

endpackage

// File: rtl/llc_pd_way_match.sv
module llc_pd_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  logic [WAYS-1:0] match;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = way_vld[g] && (way_tag[g] == look_tag);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/llc_pd_victim.sv
module llc_pd_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim,
  output logic             victim_live
);

  always_comb begin
    victim = rr_ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) victim = WAY_W'(w);
    end
    victim_live = way_vld[victim];
  end

endmodule

// File: rtl/llc_presence_dir.sv
module llc_presence_dir
  import llc_pd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int ADDR_W    = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W    = ADDR_W - IDX_W,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_op,
  input  logic [CORE_W-1:0]    req_core,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [NUM_CORES-1:0] rsp_snoop_mask,
  output logic                 rsp_excl,
  output logic                 rsp_binv_valid,
  output logic [NUM_CORES-1:0] rsp_binv_mask,
  output logic [ADDR_W-1:0]    rsp_binv_addr
);

  // directory state, one row per set
  logic [WAYS-1:0][TAG_W-1:0]     tag_q [SETS];
  logic [WAYS-1:0]                vld_q [SETS];
  logic [WAYS-1:0][NUM_CORES-1:0] pv_q  [SETS];
  logic [WAY_W-1:0]               rr_q  [SETS];

  logic                 fire;
  pd_op_e               op;
  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag;
  logic [NUM_CORES-1:0] self_bit;
  logic                 hit;
  logic [WAY_W-1:0]     hit_way;
  logic [WAY_W-1:0]     victim;
  logic                 victim_live;
  logic [NUM_CORES-1:0] pv_cur;
  logic [NUM_CORES-1:0] others;
  logic [WAY_W-1:0]     rr_next;

  assign req_ready = !rst;
  assign fire      = req_valid && req_ready;
  assign op        = pd_op_e'(req_op);
  assign idx       = req_addr[IDX_W-1:0];
  assign tag       = req_addr[ADDR_W-1:IDX_W];
  assign self_bit  = NUM_CORES'(1) << req_core;

  llc_pd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_tag (tag_q[idx]),
    .way_vld (vld_q[idx]),
    .look_tag(tag),
    .hit     (hit),
    .hit_way (hit_way)
  );

  llc_pd_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .way_vld    (vld_q[idx]),
    .rr_ptr     (rr_q[idx]),
    .victim     (victim),
    .victim_live(victim_live)
  );

  assign pv_cur  = pv_q[idx][hit_way];
  assign others  = pv_cur & ~self_bit;
  assign rr_next = (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        vld_q[s] <= '0;
        pv_q[s]  <= '0;
        rr_q[s]  <= '0;
      end
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_snoop_mask <= '0;
      rsp_excl       <= 1'b0;
      rsp_binv_valid <= 1'b0;
      rsp_binv_mask  <= '0;
      rsp_binv_addr  <= '0;
    end else begin
      rsp_valid      <= fire;
      rsp_binv_valid <= 1'b0;
      rsp_binv_mask  <= '0;
      rsp_binv_addr  <= '0;
      rsp_snoop_mask <= '0;
      rsp_excl       <= 1'b0;
      if (fire) begin
        rsp_hit <= hit;
        if (op == OP_LOOKUP) begin
          if (hit) begin
            rsp_snoop_mask         <= others;
            rsp_excl               <= (others == '0);
            pv_q[idx][hit_way]     <= pv_cur | self_bit;
          end else begin
            rsp_excl               <= 1'b1;
            rsp_binv_valid         <= victim_live;
            if (victim_live) begin
              rsp_binv_mask        <= pv_q[idx][victim];
              rsp_binv_addr        <= {tag_q[idx][victim], idx};
            end
            tag_q[idx][victim]     <= tag;
            vld_q[idx][victim]     <= 1'b1;
            pv_q[idx][victim]      <= self_bit;
            rr_q[idx]              <= rr_next;
          end
        end else begin
          if (hit) pv_q[idx][hit_way] <= pv_cur & ~self_bit;
        end
      end
    end
  end

endmodule

// File: rtl/llc_presence_dir_chk.sv
module llc_presence_dir_chk #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_op,
  input logic [CORE_W-1:0]    req_core,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [NUM_CORES-1:0] rsp_snoop_mask,
  input logic                 rsp_excl,
  input logic                 rsp_binv_valid,
  input logic [NUM_CORES-1:0] rsp_binv_mask
);

  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  p_miss_no_snoop_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_snoop_mask == '0));

  p_snoop_excludes_self_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_snoop_mask & (NUM_CORES'(1) << $past(req_core))) == '0));

  p_excl_iff_no_snoop_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_op)) |-> (rsp_excl == (rsp_snoop_mask == '0)));

  p_release_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_op)) |-> (rsp_snoop_mask == '0 && !rsp_excl && !rsp_binv_valid));

  p_binv_on_miss_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_binv_valid |-> (rsp_valid && !rsp_hit));

  p_binv_mask_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_binv_valid |-> (rsp_binv_mask == '0));

endmodule

bind llc_presence_dir llc_presence_dir_chk #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_core      (req_core),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_snoop_mask(rsp_snoop_mask),
  .rsp_excl      (rsp_excl),
  .rsp_binv_valid(rsp_binv_valid),
  .rsp_binv_mask (rsp_binv_mask)
);

// File: tb/llc_presence_dir_tb.sv
`timescale 1ns/1ps
module llc_presence_dir_tb;

  localparam int NC     = 4;
  localparam int SETS   = 4;
  localparam int WAYS   = 2;
  localparam int ADDR_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_op = 1'b0;
  logic [1:0]      req_core = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic            rsp_valid, rsp_hit, rsp_excl, rsp_binv_valid;
  logic [NC-1:0]   rsp_snoop_mask, rsp_binv_mask;
  logic [ADDR_W-1:0] rsp_binv_addr;

  always #2 clk = ~clk;

  llc_presence_dir #(.NUM_CORES(NC), .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_core(req_core), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_snoop_mask(rsp_snoop_mask),
    .rsp_excl(rsp_excl), .rsp_binv_valid(rsp_binv_valid),
    .rsp_binv_mask(rsp_binv_mask), .rsp_binv_addr(rsp_binv_addr)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int       mtag [SETS][WAYS];
  bit       mval [SETS][WAYS];
  bit [3:0] mpv  [SETS][WAYS];
  int       mrr  [SETS];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic do_req(input bit op, input int core, input int addr);
    int s, t, hw, v;
    bit h, ev, ex;
    bit [3:0] selfb, msk, bm;
    int ba;
    s = addr % SETS; t = addr / SETS; selfb = 4'(1 << core);
    h = 0; hw = 0;
    for (int w = 0; w < WAYS; w++) if (mval[s][w] && mtag[s][w] == t) begin h = 1; hw = w; end
    msk = 0; ex = 0; ev = 0; bm = 0; ba = 0;
    if (!op) begin
      if (h) begin
        msk = mpv[s][hw] & ~selfb;
        ex  = (msk == 0);
        mpv[s][hw] = mpv[s][hw] | selfb;
      end else begin
        ex = 1;
        v = mrr[s];
        for (int w = WAYS - 1; w >= 0; w--) if (!mval[s][w]) v = w;
        ev = mval[s][v];
        if (ev) begin bm = mpv[s][v]; ba = mtag[s][v] * SETS + s; end
        mtag[s][v] = t; mval[s][v] = 1; mpv[s][v] = selfb;
        mrr[s] = (mrr[s] + 1) % WAYS;
      end
    end else if (h) begin
      mpv[s][hw] = mpv[s][hw] & ~selfb;
    end
    req_valid = 1; req_op = op; req_core = 2'(core); req_addr = ADDR_W'(addr);
    @(negedge clk);
    req_valid = 0;
    chk("R10 rsp_valid", 32'(rsp_valid), 1);
    chk(op ? "R6 hit" : (h ? "R3 hit" : "R2 hit"), 32'(rsp_hit), 32'(h));
    chk(op ? "R6 snoop" : (h ? ((msk == 0) ? "R4 snoop" : "R3 R5 snoop") : "R2 snoop"),
        32'(rsp_snoop_mask), 32'(msk));
    chk("R7 excl", 32'(rsp_excl), 32'(ex));
    chk("R9 binv_valid", 32'(rsp_binv_valid), 32'(ev));
    chk("R9 binv_mask", 32'(rsp_binv_mask), 32'(bm));
    chk("R8 binv_addr", 32'(rsp_binv_addr), 32'(ba));
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R10 idle", 32'(rsp_valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL R10 watchdog actual %0d expected below 100000", cyc);
        summary();
      end
    end
  end

  initial begin
    bit [15:0] lfsr;
    for (int s = 0; s < SETS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin mtag[s][w] = 0; mval[s][w] = 0; mpv[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 binv_valid", 32'(rsp_binv_valid), 0);
    chk("R1 binv_mask", 32'(rsp_binv_mask), 0);

    // directed: sharing, release, empty-presence hit, eviction
    do_req(0, 0, 0);   // R1 first lookup misses
    do_req(0, 1, 0);   // hit, snoop core0
    do_req(1, 2, 0);   // release of clear bit
    do_req(0, 2, 0);   // snoop cores 0,1
    idle();
    do_req(1, 0, 0);
    do_req(1, 1, 0);
    do_req(1, 2, 0);   // all bits clear
    do_req(0, 3, 0);   // R4 quiet hit
    do_req(1, 3, 9);   // release of absent line
    do_req(0, 1, 4);   // second way of set 0
    do_req(0, 2, 8);   // set full: rotating pointer picks way 0
    do_req(0, 0, 12);  // pointer now way 1
    idle();

    // sweep: every core over every address of four tags per set
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 16; a++)
        do_req(0, c, a);
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 16; a++)
        do_req(1, c, (a * 5) % 16);
    idle();

    // mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_req(lfsr[1:0] == 2'b11, int'(lfsr[3:2]), int'(lfsr[8:4]));
      if (lfsr[15:12] == 4'h0) idle();
    end
    idle();
    summary();
  end

endmodule